// File: doc/BRIEF.md
# Ternary Ripple-Carry Adder

This block adds two unsigned, unbalanced ternary numbers of `N` trits each and returns an `N`-trit sum together with a carry-out trit. The full result therefore spans `N+1` trits. Each trit travels on a pair of binary wires. The three legal trit values each have their own pair code. The fourth pair code is never a legal digit.

The adder is a chain of one-trit stages. The least significant position uses a half adder, which has no carry input. Every higher position uses a full adder that sums its two operand trits and the carry trit from the stage below. The carry of the top stage becomes the carry-out.

The block is purely combinational and has no clock. A validity output tells the consumer whether both operands were well formed. When an operand holds an illegal code, the block still drives only legal codes on its result, so nothing downstream ever sees the illegal pattern.

Top module: `tern_rca_adder`

## Requirements
- R1: Trit k of any operand or result occupies bits [2k+1:2k], with trit 0 being least significant. The pair code 2'b00 means 0, 2'b01 means 1, 2'b10 means 2, and 2'b11 is illegal.
- R2: When both operands are legal, value(sum_o) + 3^N * value(cout_o) equals value(opa_i) + value(opb_i).
- R3: The least significant sum trit is (a0 + b0) mod 3, with no carry entering that position.
- R4: A carry ripples through every position. For example, an operand of all 2s plus an operand of value 1 gives a sum of all 0s and a carry-out of 1 (2'b01).
- R5: cout_o only ever carries the code 2'b00 or 2'b01 and is never 2'b10.
- R6: valid_o is 1 exactly when no trit of either operand uses the code 2'b11.
- R7: sum_o and cout_o never contain the code 2'b11, even when the operands hold illegal codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 2*N | First operand, N trits of 2 bits each |
| opb_i | input | 2*N | Second operand, N trits of 2 bits each |
| sum_o | output | 2*N | Sum, N trits |
| cout_o | output | 2 | Carry-out trit from the most significant stage |
| valid_o | output | 1 | 1 when both operands contain only legal trit codes |

## Verification
The bench sweeps every legal operand pair for the default width. This catches three kinds of error:
- a stage that mishandles a total of 3, 4 or 5, which gives a wrong sum trit or loses a carry;
- a half adder that takes a phantom carry, which shifts every result by one;
- swapped pair codes, which make values read as mirror images.

The longest ripple (all 2s plus 1) and the largest total (all 2s plus all 2s) are aimed at a carry chain that is cut or stalls partway. An illegal code is then placed at each trit position of each operand in turn. A design that misses one of those positions leaves the flag high. A design that passes the illegal code through emits 2'b11 on the sum.

// File: rtl/tern_pkg.sv
package tern_pkg;
   typedef logic [1:0] trit_t;

   localparam trit_t TRIT_ZERO = 2'b00;
   localparam trit_t TRIT_ONE  = 2'b01;
   localparam trit_t TRIT_TWO  = 2'b10;
   localparam trit_t TRIT_BAD  = 2'b11;

   // encode a small integer (0..2) into its pair code
   function automatic trit_t trit_from_int(input logic [2:0] v);
      case (v)
         3'd0:    trit_from_int = TRIT_ZERO;
         3'd1:    trit_from_int = TRIT_ONE;
         3'd2:    trit_from_int = TRIT_TWO;
         default: trit_from_int = TRIT_ZERO;
      endcase
   endfunction

   // numeric weight of a legal pair code
   function automatic logic [2:0] trit_weight(input trit_t t);
      case (t)
         TRIT_ONE: trit_weight = 3'd1;
         TRIT_TWO: trit_weight = 3'd2;
         default:  trit_weight = 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/tern_trit_screen.sv
module tern_trit_screen
   import tern_pkg::*;
(
   input  trit_t t_i,
   output trit_t t_o,
   output logic  bad_o
);
   // illegal code is flagged and replaced with zero so downstream stays legal
   always_comb begin
      bad_o = (t_i == TRIT_BAD);
      t_o   = bad_o ? TRIT_ZERO : t_i;
   end
endmodule

// File: rtl/tern_half_add.sv
module tern_half_add
   import tern_pkg::*;
(
   input  trit_t a_i,
   input  trit_t b_i,
   output trit_t s_o,
   output trit_t c_o
);
   logic [2:0] total;

   always_comb begin
      total = trit_weight(a_i) + trit_weight(b_i);
      if (total >= 3'd3) begin
         s_o = trit_from_int(total - 3'd3);
         c_o = TRIT_ONE;
      end else begin
         s_o = trit_from_int(total);
         c_o = TRIT_ZERO;
      end
   end
endmodule

// File: rtl/tern_full_add.sv
module tern_full_add
   import tern_pkg::*;
(
   input  trit_t a_i,
   input  trit_t b_i,
   input  trit_t c_i,
   output trit_t s_o,
   output trit_t c_o
);
   logic [2:0] total;

   // total ranges over 0..5, so the outgoing carry is at most one
   always_comb begin
      total = trit_weight(a_i) + trit_weight(b_i) + trit_weight(c_i);
      if (total >= 3'd3) begin
         s_o = trit_from_int(total - 3'd3);
         c_o = TRIT_ONE;
      end else begin
         s_o = trit_from_int(total);
         c_o = TRIT_ZERO;
      end
   end
endmodule

// File: rtl/tern_rca_adder.sv
module tern_rca_adder
   import tern_pkg::*;
#(
   parameter int N = 4
) (
   input  logic [2*N-1:0] opa_i,
   input  logic [2*N-1:0] opb_i,
   output logic [2*N-1:0] sum_o,
   output logic [1:0]     cout_o,
   output logic           valid_o
);
   localparam int NB = 2 * N;

   if (N < 1) begin : g_bad_width
      $error("tern_rca_adder: N must be at least 1");
   end

   trit_t        ta     [N];
   trit_t        tb     [N];
   trit_t        carry  [N];
   logic [N-1:0] bad_a;
   logic [N-1:0] bad_b;

   for (genvar k = 0; k < N; k++) begin : g_pos
      tern_trit_screen u_scr_a (
         .t_i   (opa_i[2*k +: 2]),
         .t_o   (ta[k]),
         .bad_o (bad_a[k])
      );
      tern_trit_screen u_scr_b (
         .t_i   (opb_i[2*k +: 2]),
         .t_o   (tb[k]),
         .bad_o (bad_b[k])
      );

      if (k == 0) begin : g_lsb
         tern_half_add u_ha (
            .a_i (ta[k]),
            .b_i (tb[k]),
            .s_o (sum_o[2*k +: 2]),
            .c_o (carry[k])
         );
      end else begin : g_upper
         tern_full_add u_fa (
            .a_i (ta[k]),
            .b_i (tb[k]),
            .c_i (carry[k-1]),
            .s_o (sum_o[2*k +: 2]),
            .c_o (carry[k])
         );
      end
   end

   assign cout_o  = carry[N-1];
   assign valid_o = ~(|bad_a | |bad_b);

   if (NB != 2 * N) begin : g_width_mismatch
      $error("tern_rca_adder: derived width mismatch");
   end
endmodule

// File: rtl/tern_rca_adder_chk.sv
module tern_rca_adder_chk #(
   parameter int N = 4
) (
   input logic [2*N-1:0] opa_i,
   input logic [2*N-1:0] opb_i,
   input logic [2*N-1:0] sum_o,
   input logic [1:0]     cout_o,
   input logic           valid_o
);
   function automatic longint pair_value(input logic [2*N-1:0] v);
      longint acc = 0;
      for (int k = N - 1; k >= 0; k--) acc = acc * 3 + longint'(v[2*k +: 2]);
      return acc;
   endfunction

   function automatic logic has_bad(input logic [2*N-1:0] v);
      logic b = 1'b0;
      for (int k = 0; k < N; k++) b = b | (v[2*k +: 2] == 2'b11);
      return b;
   endfunction

   longint scale;
   always_comb begin
      scale = 1;
      for (int k = 0; k < N; k++) scale = scale * 3;
   end

   always_comb begin
      if (!$isunknown({opa_i, opb_i, sum_o, cout_o, valid_o})) begin
         a_r5_cout_range: assert (cout_o == 2'b00 || cout_o == 2'b01)
            else $error("carry-out code %b out of range", cout_o);
         a_r7_no_bad_out: assert (!has_bad(sum_o) && cout_o != 2'b11)
            else $error("illegal code on result %b/%b", cout_o, sum_o);
         a_r6_valid_flag: assert (valid_o == !(has_bad(opa_i) || has_bad(opb_i)))
            else $error("validity flag %b disagrees with operands", valid_o);
         if (valid_o) begin
            a_r2_sum_value: assert (pair_value(sum_o) + scale * longint'(cout_o)
                                    == pair_value(opa_i) + pair_value(opb_i))
               else $error("sum value mismatch");
         end
      end
   end
endmodule

bind tern_rca_adder tern_rca_adder_chk #(.N(N)) chk_i (
   .opa_i   (opa_i),
   .opb_i   (opb_i),
   .sum_o   (sum_o),
   .cout_o  (cout_o),
   .valid_o (valid_o)
);

// File: tb/tern_rca_adder_tb_top.sv
module tern_rca_adder_tb_top;
   localparam int N   = 4;
   localparam int NB  = 2 * N;
   localparam int MAXV = 81; // 3^N for N = 4

   logic          clk = 1'b0;
   logic [NB-1:0] opa = '0;
   logic [NB-1:0] opb = '0;
   logic [NB-1:0] sum;
   logic [1:0]    cout;
   logic          valid;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   tern_rca_adder #(.N(N)) dut_i (
      .opa_i   (opa),
      .opb_i   (opb),
      .sum_o   (sum),
      .cout_o  (cout),
      .valid_o (valid)
   );

   // R1: trit k at bits [2k+1:2k]; 0->00, 1->01, 2->10
   function automatic logic [NB-1:0] enc(input int v);
      logic [NB-1:0] r = '0;
      int x = v;
      for (int k = 0; k < N; k++) begin
         r[2*k +: 2] = 2'(x % 3);
         x = x / 3;
      end
      return r;
   endfunction

   task automatic apply(input logic [NB-1:0] a, input logic [NB-1:0] b);
      @(negedge clk);
      opa = a;
      opb = b;
      #1;
   endtask

   task automatic check(input string req, input logic [NB+2:0] act, input logic [NB+2:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [NB+2:0] pack(input logic v, input logic [1:0] c, input logic [NB-1:0] s);
      return {v, c, s};
   endfunction

   task automatic t_reset_state;
      apply('0, '0);
      check("R1 zero operands", pack(valid, cout, sum), pack(1'b1, 2'b00, '0));
   endtask

   task automatic t_lsb_half;
      apply(enc(2), enc(2)); // 2+2 = 4 -> digit 1, carry 1 into trit 1
      check("R3 lsb 2+2", pack(valid, cout, sum), pack(1'b1, 2'b00, enc(4)));
      apply(enc(1), enc(0));
      check("R3 lsb 1+0 no phantom carry", pack(valid, cout, sum), pack(1'b1, 2'b00, enc(1)));
      apply(enc(0), enc(2));
      check("R3 lsb 0+2", pack(valid, cout, sum), pack(1'b1, 2'b00, enc(2)));
   endtask

   task automatic t_ripple;
      apply(enc(MAXV - 1), enc(1));
      check("R4 full ripple", pack(valid, cout, sum), pack(1'b1, 2'b01, '0));
      apply(enc(MAXV - 1), enc(MAXV - 1));
      check("R4 R5 largest total", pack(valid, cout, sum), pack(1'b1, 2'b01, enc(MAXV - 2)));
   endtask

   task automatic t_sweep;
      for (int a = 0; a < MAXV; a++) begin
         for (int b = 0; b < MAXV; b++) begin
            int s = a + b;
            apply(enc(a), enc(b));
            check("R2 sweep", pack(valid, cout, sum),
                  pack(1'b1, (s >= MAXV) ? 2'b01 : 2'b00, enc(s % MAXV)));
         end
      end
   endtask

   task automatic t_illegal;
      for (int k = 0; k < N; k++) begin
         for (int side = 0; side < 2; side++) begin
            logic [NB-1:0] a = enc(40);
            logic [NB-1:0] b = enc(53);
            logic legal;
            if (side == 0) a[2*k +: 2] = 2'b11;
            else           b[2*k +: 2] = 2'b11;
            apply(a, b);
            check("R6 flag low on illegal trit", {{(NB+2){1'b0}}, valid}, '0);
            legal = (cout != 2'b11) && (cout != 2'b10);
            for (int j = 0; j < N; j++) legal = legal && (sum[2*j +: 2] != 2'b11);
            check("R7 result codes legal", {{(NB+2){1'b0}}, legal}, {{(NB+2){1'b0}}, 1'b1});
         end
      end
      apply(enc(40), enc(53));
      check("R6 flag high again", {{(NB+2){1'b0}}, valid}, {{(NB+2){1'b0}}, 1'b1});
   endtask

   initial begin
      t_reset_state();
      t_lsb_half();
      t_ripple();
      t_illegal();
      t_sweep();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule